// File: doc/BRIEF.md
# Two-Phase Stable-Matching Crossbar Scheduler

This block sets up the crossbar of a small N-by-N switch that buffers cells on both the input and the output side and moves them across the fabric twice per cell time. Each time it is started it computes one conflict-free pairing of inputs to outputs that is stable with respect to two-sided preferences. An input ranks the outputs by the order of its waiting cells in its own priority queue. An output ranks the inputs by the order in which their cells would leave an ideal switch that queues only at the outputs. The pairing is ready before any cell crosses the fabric. Computing the rankings and moving the cells are left to neighbouring logic.

The scheduler latches a request mask and both rank arrays on a start pulse. It then runs input-proposing deferred acceptance, one round per clock. In each round every free input offers itself to its most preferred output that it has not yet tried. Every output keeps the best of its current partner and the new offers, and drops the rest. When no free input has an untried requested output, the scheduler pulses `done` and presents a one-hot grant vector for each output. It also presents a flag that tells which of the two transfers of the cell time the result belongs to.

Top module: `xbar_stable_match`

## Requirements
- R1: After reset, `busy`, `done`, `phase` and every `grant` bit are 0.
- R2: Each output's grant field `grant[j*N +: N]` has at most one bit set. Bit i of that field means output j is paired with input i.
- R3: Each input appears in at most one output's grant field.
- R4: A grant bit is set only for a pair whose request bit `req[i*N+j]` (input i holds a cell for output j) was set when the run started.
- R5: The result has no blocking pair. No requested, ungranted pair (i, j) exists where input i is unpaired or gives j a lower `in_rank` than its partner, and output j is unpaired or gives i a lower `out_rank` than its partner. A lower rank value means more preferred.
- R6: The result equals the input-optimal stable matching for the latched ranks. The rank fields are `in_rank[(i*N+j)*RW +: RW]` (input i's rank of output j) and `out_rank[(j*N+i)*RW +: RW]` (output j's rank of input i).
- R7: An input with no request bits set is never granted.
- R8: `done` is a one-cycle pulse that rises at most N*N+1 clocks after the clock edge that accepts `start`. It rises exactly one clock after that edge when no request bit is set.
- R9: `phase` changes only when `done` pulses. It reads 0 for the first result after reset and alternates 1, 0, 1, … on later results.
- R10: A `start` pulse that arrives while `busy` is high is ignored, and the run in progress completes with its own latched inputs.
- R11: `grant` keeps its value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a matching run; inputs are latched on the accepting edge |
| req | input | N*N | Bit i*N+j: input i has a cell for output j |
| in_rank | input | N*N*RW | Field i*N+j: input i's rank of output j, 0 is best |
| out_rank | input | N*N*RW | Field j*N+i: output j's rank of input i, 0 is best |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe: grant holds a fresh result |
| phase | output | 1 | Which of the two transfers of the cell time the result is for |
| grant | output | N*N | Bit j*N+i: output j connects to input i |

## Verification
The bench compares each result with a sequential reference that proposes one input at a time. A design that resolved several offers to the same output wrongly would pick a different partner, and the check against the reference would catch it. Blocking pairs are searched for on their own. A design that let a rejected input give up too early would leave a pair that both sides prefer, which that search would report. Empty request masks, fully loaded masks with identical preferences and sparse masks probe termination and the one-round exit. A start pulse sent into a live run checks that the latched inputs are protected. Phase alternation and grant holding are checked across consecutive results.

// File: rtl/xbar_stable_match.sv
module xbar_stable_match #(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N*N-1:0]        req,
  input  logic [N*N*((N>1)?$clog2(N):1)-1:0] in_rank,
  input  logic [N*N*((N>1)?$clog2(N):1)-1:0] out_rank,
  output logic                  busy,
  output logic                  done,
  output logic                  phase,
  output logic [N*N-1:0]        grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int RW = IW;
  localparam int NN = N * N;
  localparam int CW = $clog2(NN + 2);

  logic              busy_q, done_q, phase_q, slot_q;
  logic [NN-1:0]     req_q, tried_q, grant_q;
  logic [NN*RW-1:0]  ir_q, or_q;
  logic [N-1:0]      own_v;
  logic [IW-1:0]     own_i [N];
  logic [CW-1:0]     rcnt;

  logic [N-1:0]      in_m, prop_v, nx_v;
  logic [IW-1:0]     prop_o [N];
  logic [IW-1:0]     nx_i [N];
  logic [RW-1:0]     br [N];
  logic [NN-1:0]     nx_tried, nx_grant;

  assign busy  = busy_q;
  assign done  = done_q;
  assign phase = phase_q;
  assign grant = grant_q;

  always_comb begin
    in_m = '0;
    for (int j = 0; j < N; j++)
      if (own_v[j]) in_m[own_i[j]] = 1'b1;

    for (int i = 0; i < N; i++) begin
      prop_v[i] = 1'b0;
      prop_o[i] = '0;
      br[i]     = '0;
      for (int j = 0; j < N; j++) begin
        if (!in_m[i] && req_q[i*N+j] && !tried_q[i*N+j] &&
            (!prop_v[i] || ir_q[(i*N+j)*RW +: RW] < br[i])) begin
          prop_v[i] = 1'b1;
          prop_o[i] = IW'(j);
          br[i]     = ir_q[(i*N+j)*RW +: RW];
        end
      end
    end

    nx_tried = tried_q;
    for (int i = 0; i < N; i++)
      if (prop_v[i]) nx_tried[i*N + int'(prop_o[i])] = 1'b1;

    for (int j = 0; j < N; j++) begin
      nx_v[j] = own_v[j];
      nx_i[j] = own_i[j];
      for (int i = 0; i < N; i++) begin
        if (prop_v[i] && prop_o[i] == IW'(j) &&
            (!nx_v[j] ||
             or_q[(j*N+i)*RW +: RW] < or_q[(j*N + int'(nx_i[j]))*RW +: RW])) begin
          nx_v[j] = 1'b1;
          nx_i[j] = IW'(i);
        end
      end
    end

    nx_grant = '0;
    for (int j = 0; j < N; j++)
      if (own_v[j]) nx_grant[j*N + int'(own_i[j])] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      slot_q  <= 1'b0;
      req_q   <= '0;
      tried_q <= '0;
      grant_q <= '0;
      ir_q    <= '0;
      or_q    <= '0;
      own_v   <= '0;
      rcnt    <= '0;
      for (int j = 0; j < N; j++) own_i[j] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          req_q   <= req;
          ir_q    <= in_rank;
          or_q    <= out_rank;
          tried_q <= '0;
          own_v   <= '0;
          busy_q  <= 1'b1;
          rcnt    <= '0;
        end
      end else begin
        rcnt <= rcnt + 1'b1;
        if (|prop_v) begin
          tried_q <= nx_tried;
          own_v   <= nx_v;
          for (int j = 0; j < N; j++) own_i[j] <= nx_i[j];
        end else begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          grant_q <= nx_grant;
          phase_q <= slot_q;
          slot_q  <= ~slot_q;
        end
      end
    end
  end

  logic [NN-1:0] req_t;
  for (genvar j = 0; j < N; j++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_in
      assign req_t[j*N+i] = req_q[i*N+j];
    end
    assert_out_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q[j*N +: N]));
  end

  for (genvar i = 0; i < N; i++) begin : g_col
    logic [N-1:0] col;
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign col[j] = grant_q[j*N+i];
    end
    assert_in_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  assert_grant_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((grant_q & ~req_t) == '0));

  assert_round_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rcnt <= CW'(NN)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_grant_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grant_q) |-> done_q);

  assert_phase_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> done_q);
endmodule

// File: tb/test_xbar_stable_match.sv
module test_xbar_stable_match;
  localparam int N  = 4;
  localparam int RW = 2;
  localparam int NN = N * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NN-1:0] req = '0;
  logic [NN*RW-1:0] in_rank = '0, out_rank = '0;
  logic busy, done, phase;
  logic [NN-1:0] grant;

  xbar_stable_match #(.N(N)) i_xbar_stable_match (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .in_rank(in_rank), .out_rank(out_rank),
    .busy(busy), .done(done), .phase(phase), .grant(grant));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int ipr [N][N];
  int opr [N][N];
  bit rq  [N][N];
  int ref_m [N];
  int exp_phase = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string rid, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff) % m;
  endfunction

  task automatic perm_row(output int p [N]);
    for (int k = 0; k < N; k++) p[k] = k;
    for (int k = N - 1; k > 0; k--) begin
      int r, t;
      r = rnd(k + 1);
      t = p[k]; p[k] = p[r]; p[r] = t;
    end
  endtask

  task automatic pack();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        req[i*N+j] = rq[i][j];
        in_rank[(i*N+j)*RW +: RW]  = RW'(ipr[i][j]);
        out_rank[(j*N+i)*RW +: RW] = RW'(opr[j][i]);
      end
  endtask

  task automatic reference();
    int part [N];
    bit tr [N][N];
    bit moved;
    for (int j = 0; j < N; j++) ref_m[j] = -1;
    for (int i = 0; i < N; i++) begin
      part[i] = -1;
      for (int j = 0; j < N; j++) tr[i][j] = 0;
    end
    moved = 1;
    while (moved) begin
      moved = 0;
      for (int i = 0; i < N && !moved; i++) begin
        if (part[i] < 0) begin
          int bj = -1;
          for (int j = 0; j < N; j++)
            if (rq[i][j] && !tr[i][j] && (bj < 0 || ipr[i][j] < ipr[i][bj])) bj = j;
          if (bj >= 0) begin
            moved = 1;
            tr[i][bj] = 1;
            if (ref_m[bj] < 0) begin
              ref_m[bj] = i; part[i] = bj;
            end else if (opr[bj][i] < opr[bj][ref_m[bj]]) begin
              part[ref_m[bj]] = -1;
              ref_m[bj] = i; part[i] = bj;
            end
          end
        end
      end
    end
  endtask

  function automatic int gout(input int j);
    int r = -1;
    for (int i = 0; i < N; i++) if (grant[j*N+i]) r = (r < 0) ? i : 99;
    return r;
  endfunction

  task automatic run_case(input bit poke, input bit expect_fast);
    int c, mism, blk, cnt, idle_in;
    int gm [N];
    int ip [N];
    logic [NN-1:0] g0;
    reference();
    @(negedge clk);
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (!done && c < NN + 4) begin
      @(negedge clk);
      c++;
      if (poke && c == 1 && !done) begin
        req = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c++;
      end
    end
    chk(done == 1'b1 && c <= NN + 1, "R8", c, NN + 1);
    if (expect_fast) chk(c == 1, "R8", c, 1);
    chk(phase == exp_phase[0], "R9", phase, exp_phase);
    exp_phase = 1 - exp_phase;

    mism = 0;
    for (int j = 0; j < N; j++) begin
      gm[j] = gout(j);
      if (gm[j] != ref_m[j]) mism++;
    end
    chk(mism == 0, poke ? "R10" : "R6", mism, 0);

    for (int i = 0; i < N; i++) ip[i] = -1;
    cnt = 0;
    for (int j = 0; j < N; j++) begin
      if (gm[j] == 99) cnt++;
      else if (gm[j] >= 0) begin
        if (ip[gm[j]] >= 0) cnt++;
        ip[gm[j]] = j;
      end
    end
    chk(cnt == 0, "R2", cnt, 0);
    chk(cnt == 0, "R3", cnt, 0);

    cnt = 0; idle_in = 0;
    for (int j = 0; j < N; j++)
      if (gm[j] >= 0 && gm[j] < N && !rq[gm[j]][j]) cnt++;
    chk(cnt == 0, "R4", cnt, 0);
    for (int i = 0; i < N; i++) begin
      bit any = 0;
      for (int j = 0; j < N; j++) any |= rq[i][j];
      if (!any && ip[i] >= 0) idle_in++;
    end
    chk(idle_in == 0, "R7", idle_in, 0);

    blk = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (rq[i][j] && gm[j] != i) begin
          bit iw = (ip[i] < 0) || (ipr[i][j] < ipr[i][ip[i]]);
          bit ow = (gm[j] < 0) || (gm[j] < N && opr[j][i] < opr[j][gm[j]]);
          if (iw && ow) blk++;
        end
    chk(blk == 0, "R5", blk, 0);

    g0 = grant;
    @(negedge clk);
    @(negedge clk);
    chk(grant == g0 && !done, "R11", int'(grant), int'(g0));
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && phase == 0 && grant == '0, "R1", int'(grant), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rq[i][j] = 0; ipr[i][j] = j; opr[i][j] = j;
      end
    run_case(0, 1);

    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) rq[i][j] = 1;
    run_case(0, 0);

    for (int t = 0; t < 300; t++) begin
      int dens = 1 + (t % 4);
      for (int i = 0; i < N; i++) begin
        int p [N];
        perm_row(p);
        for (int j = 0; j < N; j++) ipr[i][j] = p[j];
        perm_row(p);
        for (int j = 0; j < N; j++) opr[i][j] = p[j];
        for (int j = 0; j < N; j++) rq[i][j] = (rnd(4) < dens);
        if (t % 7 == 3) for (int j = 0; j < N; j++) rq[i][j] = 0;
      end
      run_case(t % 5 == 2, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule